// File: doc/BRIEF.md
# Multiplexed External Memory Bank Controller

This block runs asynchronous read and write cycles on one external memory bank that is split into four sub-banks. Each sub-bank has its own active-low chip-select line and its own configuration register. The remaining external pins are shared by all four sub-banks. A host presents a request with an address, a write flag and write data. The two address bits above the 26-bit device range pick the sub-bank. The block then asserts that sub-bank's chip select and steps through an address phase, an optional address-hold phase and a data phase. The length of each phase comes from the chosen sub-bank's register.

A configuration register can select multiplexed mode. In that mode the 16 shared data lines first carry device address bits [15:0], framed by an active-low address-valid strobe, and only then carry data. Address bits [25:16] stay on the dedicated address pins for the whole access. In non-multiplexed mode the full address is driven on the dedicated pins and the data lines carry only data. Every output is decoded from registers that update on the rising clock edge. Each external pin therefore changes only at that edge.

The bidirectional data lines appear as three signals: a drive value, a drive enable and a sampled input. A pad ring joins them outside the block.

Top module: `mux_mem_bank`

## Requirements
- R1: `req_addr[27:26]` selects the sub-bank. During an access only that sub-bank's `mem_ce_n` bit is low (bit index equals the sub-bank number). At most one chip select is ever low.
- R2: Each sub-bank has its own configuration register, written with `cfg_we`/`cfg_sel`. Field layout: bit 12 = multiplexed mode, [11:8] = address-phase length, [7:4] = hold-phase length, [3:0] = data-phase length, all lengths in clock cycles. Reset value is multiplexed mode with every length 1. An access uses only its own sub-bank's register.
- R3: In multiplexed mode the address phase lasts the programmed number of cycles. During it `mem_adv_n` is low, `mem_ad_oe` is 1 and `mem_ad_out` carries device address bits [15:0].
- R4: In multiplexed mode a hold phase of the programmed length follows the address phase. During it `mem_adv_n` is high and the data lines still drive address bits [15:0].
- R5: `mem_addr` carries device address bits [25:0] unchanged from the first cycle of an access to its last.
- R6: In non-multiplexed mode `mem_adv_n` stays high and no hold phase occurs. The address phase keeps the programmed length with the data lines released.
- R7: A write data phase lasts the programmed number of cycles. During it `mem_we_n` is low, `mem_oe_n` is high, `mem_ad_oe` is 1 and `mem_ad_out` equals the request's write data.
- R8: A read data phase lasts the programmed number of cycles. During it `mem_oe_n` is low, `mem_we_n` is high and `mem_ad_oe` is 0. `rdata` takes the value of `mem_ad_in` sampled on the final data-phase cycle.
- R9: `done` pulses for exactly one cycle, in the cycle after the last data-phase cycle. `busy` is high from the cycle after acceptance until then. Requests presented while `busy` is high are ignored.
- R10: A programmed phase length of 0 behaves as a length of 1.
- R11: After reset and between accesses, all chip selects, `mem_adv_n`, `mem_oe_n` and `mem_we_n` are high, `mem_ad_oe` is 0 and `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_sel | input | 2 | Sub-bank whose register is written |
| cfg_wdata | input | 13 | Configuration value (mode and three phase lengths) |
| req_valid | input | 1 | Host request present; taken when idle |
| req_addr | input | 28 | Sub-bank number [27:26] and device address [25:0] |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle access completion pulse |
| rdata | output | 16 | Data captured by the last read |
| mem_ce_n | output | 4 | Per-sub-bank chip selects, active low |
| mem_addr | output | 26 | Dedicated address pins |
| mem_adv_n | output | 1 | Address-valid strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ad_out | output | 16 | Value driven onto the shared address/data lines |
| mem_ad_oe | output | 1 | Drive enable for the shared lines |
| mem_ad_in | input | 16 | Value sampled from the shared lines |

## Verification
A request is taken at the rising edge where it is seen while idle. The pins show the first address-phase cycle right after that edge. With phase lengths A, H (zero in non-multiplexed mode) and D, the chip select stays low for A+H+D cycles, and `done` with the new `rdata` appears A+H+D edges after acceptance. The bench samples on falling edges and steps through every cycle of every access, comparing each pin against the phase that cycle belongs to. During read data phases it changes `mem_ad_in` every cycle, so only a capture on the final cycle gives the expected `rdata`.

// File: rtl/mbk_pkg.sv
package mbk_pkg;

    localparam int NSUB  = 4;
    localparam int SUB_W = $clog2(NSUB);
    localparam int PH_W  = 4;
    localparam int CFG_W = 1 + 3 * PH_W;

    typedef struct packed {
        logic            muxed;
        logic [PH_W-1:0] adr_len;
        logic [PH_W-1:0] hld_len;
        logic [PH_W-1:0] dat_len;
    } bank_cfg_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_HOLD = 2'd2,
        PH_DATA = 2'd3
    } bus_phase_e;

    localparam bank_cfg_t CFG_RESET = '{
        muxed:   1'b1,
        adr_len: PH_W'(1),
        hld_len: PH_W'(1),
        dat_len: PH_W'(1)
    };

    // Counter load for a phase: cycles minus one, a zero length counts as one.
    function automatic logic [PH_W-1:0] phase_load(input logic [PH_W-1:0] len);
        return (len == '0) ? '0 : len - 1'b1;
    endfunction

endpackage

// File: rtl/mbk_cfg_bank.sv
module mbk_cfg_bank
    import mbk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SUB_W-1:0] wr_sel,
    input  bank_cfg_t        wr_cfg,
    input  logic [SUB_W-1:0] rd_sel,
    output bank_cfg_t        rd_cfg
);

    bank_cfg_t regs [NSUB];

    for (genvar g = 0; g < NSUB; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= CFG_RESET;
            end else if (wr_en && (wr_sel == SUB_W'(g))) begin
                regs[g] <= wr_cfg;
            end
        end
    end

    assign rd_cfg = regs[rd_sel];

endmodule

// File: rtl/mbk_seq.sv
module mbk_seq
    import mbk_pkg::*;
#(
    parameter int ADDR_W = 26,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_dev_addr,
    input  logic [SUB_W-1:0]  req_sub,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  bank_cfg_t         sel_cfg,
    input  logic [DATA_W-1:0] bus_in,
    output bus_phase_e        phase,
    output logic              cur_muxed,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [SUB_W-1:0]  cur_sub,
    output logic              cur_write,
    output logic [DATA_W-1:0] cur_wdata,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);

    bank_cfg_t       cur_cfg;
    logic [PH_W-1:0] cnt;
    logic            last_cyc;

    assign last_cyc  = (cnt == '0);
    assign cur_muxed = cur_cfg.muxed;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            cnt       <= '0;
            cur_cfg   <= CFG_RESET;
            cur_addr  <= '0;
            cur_sub   <= '0;
            cur_write <= 1'b0;
            cur_wdata <= '0;
            done      <= 1'b0;
            rdata     <= '0;
        end else begin
            done <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (req_valid) begin
                        cur_cfg   <= sel_cfg;
                        cur_addr  <= req_dev_addr;
                        cur_sub   <= req_sub;
                        cur_write <= req_write;
                        cur_wdata <= req_wdata;
                        cnt       <= phase_load(sel_cfg.adr_len);
                        phase     <= PH_ADDR;
                    end
                end
                PH_ADDR: begin
                    if (!last_cyc) begin
                        cnt <= cnt - 1'b1;
                    end else if (cur_cfg.muxed) begin
                        cnt   <= phase_load(cur_cfg.hld_len);
                        phase <= PH_HOLD;
                    end else begin
                        cnt   <= phase_load(cur_cfg.dat_len);
                        phase <= PH_DATA;
                    end
                end
                PH_HOLD: begin
                    if (!last_cyc) begin
                        cnt <= cnt - 1'b1;
                    end else begin
                        cnt   <= phase_load(cur_cfg.dat_len);
                        phase <= PH_DATA;
                    end
                end
                PH_DATA: begin
                    if (!last_cyc) begin
                        cnt <= cnt - 1'b1;
                    end else begin
                        if (!cur_write) begin
                            rdata <= bus_in;
                        end
                        done  <= 1'b1;
                        phase <= PH_IDLE;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R9: completion follows a data-phase cycle only
    p_done_after_data_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(phase) == PH_DATA);

    // R9: a running access ignores new requests
    p_busy_ignores_req_r9: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE && $past(phase) != PH_IDLE)
            |-> ($stable(cur_addr) && $stable(cur_sub) && $stable(cur_write)));

    // R6: hold phase is entered only in multiplexed mode
    p_hold_only_muxed_r6: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HOLD) |-> cur_cfg.muxed);

    // R2: the captured configuration stays fixed during an access
    p_cfg_frozen_r2: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE && $past(phase) != PH_IDLE) |-> $stable(cur_cfg));

endmodule

// File: rtl/mbk_pin_drv.sv
module mbk_pin_drv
    import mbk_pkg::*;
#(
    parameter int ADDR_W = 26,
    parameter int DATA_W = 16
) (
    input  bus_phase_e        phase,
    input  logic              cur_muxed,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [SUB_W-1:0]  cur_sub,
    input  logic              cur_write,
    input  logic [DATA_W-1:0] cur_wdata,
    output logic [NSUB-1:0]   ce_n,
    output logic [ADDR_W-1:0] addr_pins,
    output logic              adv_n,
    output logic              oe_n,
    output logic              we_n,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe
);

    logic active;
    logic addr_on_bus;
    logic in_data;

    assign active      = (phase != PH_IDLE);
    assign in_data     = (phase == PH_DATA);
    assign addr_on_bus = cur_muxed && ((phase == PH_ADDR) || (phase == PH_HOLD));

    for (genvar g = 0; g < NSUB; g++) begin : g_cs
        assign ce_n[g] = !(active && (cur_sub == SUB_W'(g)));
    end

    always_comb begin
        addr_pins = active ? cur_addr : '0;
        adv_n     = !(cur_muxed && (phase == PH_ADDR));
        oe_n      = !(in_data && !cur_write);
        we_n      = !(in_data && cur_write);
        ad_oe     = addr_on_bus || (in_data && cur_write);
        if (addr_on_bus) begin
            ad_out = cur_addr[DATA_W-1:0];
        end else if (in_data && cur_write) begin
            ad_out = cur_wdata;
        end else begin
            ad_out = '0;
        end
    end

endmodule

// File: rtl/mux_mem_bank.sv
module mux_mem_bank
    import mbk_pkg::*;
#(
    parameter int ADDR_W = 26,
    parameter int DATA_W = 16,
    localparam int HOST_W = ADDR_W + SUB_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [SUB_W-1:0]  cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              req_valid,
    input  logic [HOST_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [NSUB-1:0]   mem_ce_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_adv_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_ad_out,
    output logic              mem_ad_oe,
    input  logic [DATA_W-1:0] mem_ad_in
);

    bank_cfg_t         sel_cfg;
    bus_phase_e        phase;
    logic              cur_muxed;
    logic [ADDR_W-1:0] cur_addr;
    logic [SUB_W-1:0]  cur_sub;
    logic              cur_write;
    logic [DATA_W-1:0] cur_wdata;
    logic [SUB_W-1:0]  req_sub;

    assign req_sub = req_addr[HOST_W-1:ADDR_W];
    assign busy    = (phase != PH_IDLE);

    mbk_cfg_bank u_cfg (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (cfg_we),
        .wr_sel (cfg_sel),
        .wr_cfg (bank_cfg_t'(cfg_wdata)),
        .rd_sel (req_sub),
        .rd_cfg (sel_cfg)
    );

    mbk_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_dev_addr (req_addr[ADDR_W-1:0]),
        .req_sub      (req_sub),
        .req_write    (req_write),
        .req_wdata    (req_wdata),
        .sel_cfg      (sel_cfg),
        .bus_in       (mem_ad_in),
        .phase        (phase),
        .cur_muxed    (cur_muxed),
        .cur_addr     (cur_addr),
        .cur_sub      (cur_sub),
        .cur_write    (cur_write),
        .cur_wdata    (cur_wdata),
        .done         (done),
        .rdata        (rdata)
    );

    mbk_pin_drv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .phase     (phase),
        .cur_muxed (cur_muxed),
        .cur_addr  (cur_addr),
        .cur_sub   (cur_sub),
        .cur_write (cur_write),
        .cur_wdata (cur_wdata),
        .ce_n      (mem_ce_n),
        .addr_pins (mem_addr),
        .adv_n     (mem_adv_n),
        .oe_n      (mem_oe_n),
        .we_n      (mem_we_n),
        .ad_out    (mem_ad_out),
        .ad_oe     (mem_ad_oe)
    );

    // R1: never more than one chip select low
    p_one_cs_r1: assert property (@(posedge clk) disable iff (rst)
        $countones(~mem_ce_n) <= 1);

    // R11: idle bank keeps all strobes inactive
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (&mem_ce_n && mem_adv_n && mem_oe_n && mem_we_n && !mem_ad_oe));

    // R5: dedicated address pins hold still through an access
    p_addr_stable_r5: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(mem_addr));

    // R8: the block never drives the shared lines while the device may
    p_no_contention_r8: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> !mem_ad_oe);

    // R7: read and write strobes are mutually exclusive
    p_strobe_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(!mem_oe_n && !mem_we_n));

    // R3: the address strobe appears only in multiplexed mode with the lines driven
    p_adv_driven_r3: assert property (@(posedge clk) disable iff (rst)
        !mem_adv_n |-> (mem_ad_oe && mem_oe_n && mem_we_n));

endmodule

// File: tb/tb_mux_mem_bank.sv
module tb_mux_mem_bank;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [1:0]  cfg_sel;
    logic [12:0] cfg_wdata;
    logic        req_valid;
    logic [27:0] req_addr;
    logic        req_write;
    logic [15:0] req_wdata;
    logic        busy, done;
    logic [15:0] rdata;
    logic [3:0]  mem_ce_n;
    logic [25:0] mem_addr;
    logic        mem_adv_n, mem_oe_n, mem_we_n, mem_ad_oe;
    logic [15:0] mem_ad_out;
    logic [15:0] mem_ad_in;

    always #5 clk = ~clk;

    mux_mem_bank dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
        .req_wdata(req_wdata), .busy(busy), .done(done), .rdata(rdata),
        .mem_ce_n(mem_ce_n), .mem_addr(mem_addr), .mem_adv_n(mem_adv_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_ad_out(mem_ad_out),
        .mem_ad_oe(mem_ad_oe), .mem_ad_in(mem_ad_in)
    );

    int n_chk  = 0;
    int n_fail = 0;

    logic mdl_mux [4];
    int   mdl_a   [4];
    int   mdl_h   [4];
    int   mdl_d   [4];

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic logic [31:0] rnd();
        return $urandom;
    endfunction

    function automatic logic [15:0] tok(input int j, input logic [25:0] a);
        return 16'hA55A ^ 16'(j * 16'h0111) ^ a[15:0];
    endfunction

    task automatic wr_cfg(input int sub, input logic m, input int a, input int h, input int d);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_sel   = sub[1:0];
        cfg_wdata = {m, a[3:0], h[3:0], d[3:0]};
        mdl_mux[sub] = m;
        mdl_a[sub]   = a;
        mdl_h[sub]   = h;
        mdl_d[sub]   = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic access(input string ctx, input int sub, input logic [25:0] a,
                          input logic wr, input logic [15:0] wd, input bit noisy);
        int A, H, D, tot;
        logic m;
        logic [3:0] exp_ce;
        logic [3:0] exp_sig;
        logic [31:0] r;
        m   = mdl_mux[sub];
        A   = eff(mdl_a[sub]);
        H   = m ? eff(mdl_h[sub]) : 0;
        D   = eff(mdl_d[sub]);
        tot = A + H + D;
        exp_ce = 4'hF;
        exp_ce[sub] = 1'b0;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = {sub[1:0], a};
        req_write = wr;
        req_wdata = wd;
        for (int k = 0; k < tot; k++) begin
            @(negedge clk);
            if (noisy && k < tot - 1) begin
                r = rnd();
                req_valid = 1'b1;
                req_addr  = r[27:0];
                req_write = r[31];
                req_wdata = r[15:0] ^ 16'h3C3C;
            end else begin
                req_valid = 1'b0;
            end
            chk({ctx, " R1 chip select"}, 32'(mem_ce_n), 32'(exp_ce));
            chk({ctx, " R5 address pins"}, 32'(mem_addr), 32'(a));
            chk({ctx, " R9 busy"}, 32'(busy), 32'd1);
            // signal vector: {adv_n, oe_n, we_n, ad_oe}
            if (k < A) begin
                exp_sig = m ? 4'b0111 : 4'b1110;
                chk({ctx, m ? " R3 addr phase" : " R6 addr phase"},
                    32'({mem_adv_n, mem_oe_n, mem_we_n, mem_ad_oe}), 32'(exp_sig));
                if (m) chk({ctx, " R3 muxed address"}, 32'(mem_ad_out), 32'(a[15:0]));
            end else if (k < A + H) begin
                chk({ctx, " R4 hold phase"},
                    32'({mem_adv_n, mem_oe_n, mem_we_n, mem_ad_oe}), 32'(4'b1111));
                chk({ctx, " R4 held address"}, 32'(mem_ad_out), 32'(a[15:0]));
            end else if (wr) begin
                chk({ctx, " R7 write phase"},
                    32'({mem_adv_n, mem_oe_n, mem_we_n, mem_ad_oe}), 32'(4'b1101));
                chk({ctx, " R7 write data"}, 32'(mem_ad_out), 32'(wd));
            end else begin
                chk({ctx, " R8 read phase"},
                    32'({mem_adv_n, mem_oe_n, mem_we_n, mem_ad_oe}), 32'(4'b1010));
                mem_ad_in = tok(k - A - H, a);
            end
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk({ctx, " R9 done pulse"}, 32'(done), 32'd1);
        chk({ctx, " R11 idle after access"},
            32'({busy, mem_ce_n, mem_adv_n, mem_oe_n, mem_we_n, mem_ad_oe}), 32'(8'b0_1111_111_0));
        if (!wr) chk({ctx, " R8 read capture"}, 32'(rdata), 32'(tok(D - 1, a)));
        @(negedge clk);
        chk({ctx, " R9 done single cycle"}, 32'(done), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=complete");
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
        req_valid = 1'b0; req_addr = '0; req_write = 1'b0; req_wdata = '0;
        mem_ad_in = '0;
        for (int i = 0; i < 4; i++) begin
            mdl_mux[i] = 1'b1; mdl_a[i] = 1; mdl_h[i] = 1; mdl_d[i] = 1;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 reset state",
            32'({busy, done, mem_ce_n, mem_adv_n, mem_oe_n, mem_we_n, mem_ad_oe}),
            32'(9'b00_1111_111_0));

        // R2: reset configuration (muxed, all lengths 1)
        access("R2 reset cfg", 2, 26'h2ABCDE, 1'b0, 16'h0, 1'b0);

        // R2: distinct per sub-bank settings
        wr_cfg(0, 1'b1, 3, 2, 4);
        wr_cfg(1, 1'b0, 2, 5, 3);
        wr_cfg(2, 1'b1, 1, 3, 2);
        wr_cfg(3, 1'b0, 4, 1, 5);
        access("R2 sub0 wr", 0, 26'h0001234, 1'b1, 16'hBEEF, 1'b0);
        access("R2 sub1 rd", 1, 26'h3FFFFFF, 1'b0, 16'h0, 1'b0);
        access("R2 sub2 rd", 2, 26'h1550AA5, 1'b0, 16'h0, 1'b0);
        access("R2 sub3 wr", 3, 26'h2000001, 1'b1, 16'h1357, 1'b0);

        // R9: requests during an access are ignored
        access("R9 noisy rd", 0, 26'h0A0A0A0, 1'b0, 16'h0, 1'b1);
        access("R9 noisy wr", 3, 26'h1234567, 1'b1, 16'hC0DE, 1'b1);

        // R10: zero lengths act as one
        wr_cfg(1, 1'b1, 0, 0, 0);
        access("R10 zero muxed", 1, 26'h0FEDCBA, 1'b0, 16'h0, 1'b0);
        wr_cfg(1, 1'b0, 0, 0, 0);
        access("R10 zero plain", 1, 26'h0000000, 1'b1, 16'hFFFF, 1'b0);

        // random mix
        for (int it = 0; it < 40; it++) begin
            logic [31:0] r;
            logic [31:0] r2;
            r  = rnd();
            r2 = rnd();
            if (it % 5 == 0) begin
                wr_cfg(int'(r[1:0]), r[2], int'(r[6:3]) % 6, int'(r[10:7]) % 6, int'(r[14:11]) % 6);
            end
            access("RND", int'(r2[27:26]), r2[25:0], r[20], r[31:16], (it % 3) == 0);
        end

        summary();
    end

endmodule